// File: doc/BRIEF.md
# Pipelined Eight-Key Odd-Even Merge Sorter

This block takes eight unsigned keys in parallel together with a valid flag and returns the same eight keys in ascending order six clock cycles later. Internally it is a fixed network of compare-exchange cells. Each cell makes one magnitude comparison, and that single result steers two multiplexers, one for the smaller key and one for the larger. The cells are wired as an odd-even merge. The first layer sorts neighbouring pairs. The next two layers merge those pairs into ordered quadruples. The last three layers merge the two quadruples into a single ordered octet.

A register bank follows every layer, so all six layers work on six different key sets in the same cycle. A new set may therefore be presented on every clock edge with no gaps. The valid flag moves down the pipeline beside the keys. Only the valid flags are cleared by reset; the key registers have no reset. The key width is a parameter. The lane count is fixed at eight, and the layer count of six is derived from it.

Top module: `oddeven_sort8`

## Requirements
- R1: Whenever `res_vld` is high, the result lanes are in non-decreasing unsigned order. Lane 0 holds bits [KEY_W-1:0] of the bus and is the smallest; lane i holds bits [i*KEY_W +: KEY_W].
- R2: Whenever `res_vld` is high, the multiset of keys on `res_keys` equals the multiset that was presented with the matching input beat.
- R3: `res_vld` equals `src_vld` as sampled six rising edges earlier. An input beat with `src_vld` low yields no result beat.
- R4: A new key set may be accepted on every cycle. Sets presented on consecutive cycles emerge on consecutive cycles and do not affect each other.
- R5: A synchronous active-high `rst` clears every valid stage. Beats presented while `rst` is high are discarded, and `res_vld` stays low for the first six edges after reset is released.
- R6: Sets with repeated keys, including sets where all eight keys are equal, are sorted correctly. The relative order of equal keys is not specified.
- R7: Input sets that are already ascending, or strictly descending, come out in ascending order.
- R8: Keys are compared as unsigned numbers, so a key with its most significant bit set sorts above every key whose most significant bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| src_vld | input | 1 | High when `src_keys` carries a set to be sorted |
| src_keys | input | 8*KEY_W | Eight unsorted keys, lane i at bits [i*KEY_W +: KEY_W] |
| res_vld | output | 1 | High when `res_keys` carries a sorted set |
| res_keys | output | 8*KEY_W | Eight sorted keys, ascending from lane 0 to lane 7 |

## Verification
The bench runs the network through all 256 sets built from only the smallest and the largest key. By the zero-one principle, a comparator that is miswired or missing must then leave some result out of order. It also sends long runs of random sets on consecutive cycles, so that a stage which leaks data between neighbouring beats, or a layer whose registers are skipped, shows up as mismatched keys or as a valid flag in the wrong cycle. Inputs that are all equal, full of duplicates, already ascending or fully descending are aimed at a comparator with a reversed select or a lost swap. Sets that mix keys with and without the top bit set would expose a signed comparison as a wrap-around order. Beats offered during reset must never appear at the output, which a pipeline with an unreset valid flag would fail.

// File: rtl/oddeven_sort8_pkg.sv
package oddeven_sort8_pkg;

    localparam int LANES  = 8;
    localparam int LG     = $clog2(LANES);
    localparam int STAGES = LG * (LG + 1) / 2;

    // Merge span p of layer s: layers are numbered in (p, k) order with
    // p = 1, 2, 4 ... and k running from p down to 1 inside each p.
    function automatic int stg_span(input int s);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int lp = 0; lp < LG; lp++) begin
            for (int lk = lp; lk >= 0; lk--) begin
                if (idx == s) res = 1 << lp;
                idx++;
            end
        end
        return res;
    endfunction

    // Compare distance k of layer s.
    function automatic int stg_dist(input int s);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int lp = 0; lp < LG; lp++) begin
            for (int lk = lp; lk >= 0; lk--) begin
                if (idx == s) res = 1 << lk;
                idx++;
            end
        end
        return res;
    endfunction

    // True when lane a is the lower input of a comparator in layer s.
    function automatic bit lo_side(input int s, input int a);
        int p;
        int k;
        int off;
        p   = stg_span(s);
        k   = stg_dist(s);
        off = k % p;
        return (a >= off) && (((a - off) % (2 * k)) < k) && (a + k < LANES)
            && ((a / (2 * p)) == ((a + k) / (2 * p)));
    endfunction

endpackage

// File: rtl/oe_cmpx.sv
module oe_cmpx #(
    parameter int KEY_W = 16
) (
    input  logic [KEY_W-1:0] a_i,
    input  logic [KEY_W-1:0] b_i,
    output logic [KEY_W-1:0] lo_o,
    output logic [KEY_W-1:0] hi_o
);

    logic swap;

    // One comparison drives the select of both multiplexers.
    assign swap = a_i > b_i;
    assign lo_o = swap ? b_i : a_i;
    assign hi_o = swap ? a_i : b_i;

endmodule

// File: rtl/oe_stage.sv
module oe_stage
    import oddeven_sort8_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int STG   = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic [LANES*KEY_W-1:0] in_keys,
    output logic                   out_vld,
    output logic [LANES*KEY_W-1:0] out_keys
);

    localparam int K = stg_dist(STG);

    typedef struct packed {
        logic                   vld;
        logic [LANES*KEY_W-1:0] keys;
    } beat_t;

    logic [KEY_W-1:0] net_w [LANES];
    beat_t            beat_d;
    beat_t            beat_q;

    for (genvar a = 0; a < LANES; a++) begin : g_lane
        if (lo_side(STG, a)) begin : g_cmp
            oe_cmpx #(.KEY_W(KEY_W)) u_cx (
                .a_i  (in_keys[a*KEY_W +: KEY_W]),
                .b_i  (in_keys[(a+K)*KEY_W +: KEY_W]),
                .lo_o (net_w[a]),
                .hi_o (net_w[a+K])
            );
        end else if (!(a >= K && lo_side(STG, a - K))) begin : g_pass
            assign net_w[a] = in_keys[a*KEY_W +: KEY_W];
        end
    end

    always_comb begin
        beat_d.vld = in_vld;
        for (int i = 0; i < LANES; i++) begin
            beat_d.keys[i*KEY_W +: KEY_W] = net_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q.vld <= 1'b0;
        end else begin
            beat_q.vld <= beat_d.vld;
        end
        beat_q.keys <= beat_d.keys;
    end

    assign out_vld  = beat_q.vld;
    assign out_keys = beat_q.keys;

endmodule

// File: rtl/oddeven_sort8.sv
module oddeven_sort8
    import oddeven_sort8_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   src_vld,
    input  logic [LANES*KEY_W-1:0] src_keys,
    output logic                   res_vld,
    output logic [LANES*KEY_W-1:0] res_keys
);

    localparam int BUS_W = LANES * KEY_W;

    logic [STAGES:0] vld_c;
    logic [BUS_W-1:0] keys_c [STAGES+1];

    assign vld_c[0]  = src_vld;
    assign keys_c[0] = src_keys;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        oe_stage #(.KEY_W(KEY_W), .STG(s)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (vld_c[s]),
            .in_keys  (keys_c[s]),
            .out_vld  (vld_c[s+1]),
            .out_keys (keys_c[s+1])
        );
    end

    assign res_vld  = vld_c[STAGES];
    assign res_keys = keys_c[STAGES];

endmodule

// File: rtl/oddeven_sort8_chk.sv
module oddeven_sort8_chk
    import oddeven_sort8_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   src_vld,
    input logic [LANES*KEY_W-1:0] src_keys,
    input logic                   res_vld,
    input logic [LANES*KEY_W-1:0] res_keys
);

    localparam int CNT_W = $clog2(STAGES + 1);
    localparam int SUM_W = KEY_W + LG;

    logic [CNT_W-1:0] fill_q;
    logic [SUM_W-1:0] src_sum;
    logic [SUM_W-1:0] res_sum;
    logic [KEY_W-1:0] src_min;
    logic [KEY_W-1:0] src_max;
    logic             res_ord;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (fill_q != CNT_W'(STAGES)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        src_sum = '0;
        res_sum = '0;
        src_min = src_keys[KEY_W-1:0];
        src_max = src_keys[KEY_W-1:0];
        res_ord = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            src_sum = src_sum + {{LG{1'b0}}, src_keys[i*KEY_W +: KEY_W]};
            res_sum = res_sum + {{LG{1'b0}}, res_keys[i*KEY_W +: KEY_W]};
            if (src_keys[i*KEY_W +: KEY_W] < src_min) src_min = src_keys[i*KEY_W +: KEY_W];
            if (src_keys[i*KEY_W +: KEY_W] > src_max) src_max = src_keys[i*KEY_W +: KEY_W];
        end
        for (int i = 0; i < LANES - 1; i++) begin
            if (res_keys[i*KEY_W +: KEY_W] > res_keys[(i+1)*KEY_W +: KEY_W]) res_ord = 1'b0;
        end
    end

    AST_VLD_FILL: assert property (@(posedge clk) disable iff (rst)
        (fill_q < CNT_W'(STAGES)) |-> !res_vld); // R5
    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
        (fill_q == CNT_W'(STAGES)) |-> (res_vld == $past(src_vld, 6))); // R3
    AST_RES_ORDER: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> res_ord); // R1
    AST_SUM_KEPT: assert property (@(posedge clk) disable iff (rst)
        (fill_q == CNT_W'(STAGES) && res_vld) |-> (res_sum == $past(src_sum, 6))); // R2
    AST_MIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (fill_q == CNT_W'(STAGES) && res_vld) |-> (res_keys[KEY_W-1:0] == $past(src_min, 6))); // R2
    AST_MAX_LAST: assert property (@(posedge clk) disable iff (rst)
        (fill_q == CNT_W'(STAGES) && res_vld)
            |-> (res_keys[(LANES-1)*KEY_W +: KEY_W] == $past(src_max, 6))); // R8

endmodule

bind oddeven_sort8 oddeven_sort8_chk #(.KEY_W(KEY_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .src_vld  (src_vld),
    .src_keys (src_keys),
    .res_vld  (res_vld),
    .res_keys (res_keys)
);

// File: tb/test_oddeven_sort8.sv
`timescale 1ns/1ps
module test_oddeven_sort8;
    import oddeven_sort8_pkg::*;

    localparam int W   = 4;
    localparam int N   = LANES;
    localparam int BW  = N * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_vld = 1'b0;
    logic [BW-1:0] src_keys = '0;
    logic          res_vld;
    logic [BW-1:0] res_keys;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic          ring_vld  [8];
    logic [BW-1:0] ring_keys [8];
    string         ring_tag  [8];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    oddeven_sort8 #(.KEY_W(W)) i_oddeven_sort8 (
        .clk      (clk),
        .rst      (rst),
        .src_vld  (src_vld),
        .src_keys (src_keys),
        .res_vld  (res_vld),
        .res_keys (res_keys)
    );

    function automatic logic [BW-1:0] ref_sort(input logic [BW-1:0] k);
        logic [W-1:0] v [N];
        logic [W-1:0] t;
        logic [BW-1:0] r;
        for (int i = 0; i < N; i++) v[i] = k[i*W +: W];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (v[j-1] > v[j]) begin
                    t = v[j]; v[j] = v[j-1]; v[j-1] = t;
                end
            end
        end
        for (int i = 0; i < N; i++) r[i*W +: W] = v[i];
        return r;
    endfunction

    function automatic logic [BW-1:0] flip_lanes(input logic [BW-1:0] k);
        logic [BW-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = k[(N-1-i)*W +: W];
        return r;
    endfunction

    function automatic logic [BW-1:0] rnd_keys(input int range_n);
        logic [BW-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom_range(range_n - 1));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic drive(input bit r, input bit v, input logic [BW-1:0] k, input string tag);
        @(negedge clk);
        rst      = r;
        src_vld  = v;
        src_keys = k;
        ring_vld[cyc % 8]  = v && !r;
        ring_keys[cyc % 8] = k;
        ring_tag[cyc % 8]  = tag;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            ring_vld[i]  = 1'b0;
            ring_keys[i] = '0;
            ring_tag[i]  = "R3";
        end
    end

    // Output monitor: the entry driven six cycles ago is due now.
    always @(negedge clk) begin
        if (!done) begin
            int idx;
            bit ord;
            idx = (cyc + 2) % 8;
            check(res_vld === ring_vld[idx], rst ? "R5" : "R3", "res_vld",
                  BW'(res_vld), BW'(ring_vld[idx]));
            if (ring_vld[idx] && res_vld === 1'b1) begin
                ord = 1'b1;
                for (int i = 0; i < N - 1; i++)
                    if (res_keys[i*W +: W] > res_keys[(i+1)*W +: W]) ord = 1'b0;
                check(ord, "R1", "lane order", res_keys, ref_sort(res_keys));
                check(res_keys === ref_sort(ring_keys[idx]), ring_tag[idx], "sorted keys",
                      res_keys, ref_sort(ring_keys[idx]));
            end
        end
    end

    initial begin
        logic [BW-1:0] k;
        // R5: beats offered during reset must vanish
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, rnd_keys(16), "R5");
        // R2: zero-one sweep with extreme keys, back to back
        for (int b = 0; b < 256; b++) begin
            for (int i = 0; i < N; i++) k[i*W +: W] = b[i] ? {W{1'b1}} : '0;
            drive(1'b0, 1'b1, k, "R2");
        end
        // R4: random sets on every cycle
        for (int i = 0; i < 1500; i++) drive(1'b0, 1'b1, rnd_keys(16), "R4");
        // R3: random sets with gaps in the valid flag
        for (int i = 0; i < 300; i++) drive(1'b0, 1'($urandom_range(1)), rnd_keys(16), "R2");
        // R7: already ascending and fully descending inputs
        for (int i = 0; i < 30; i++) begin
            k = ref_sort(rnd_keys(16));
            drive(1'b0, 1'b1, k, "R7");
            drive(1'b0, 1'b1, flip_lanes(k), "R7");
        end
        // R6: all equal and heavy duplicates
        for (int i = 0; i < 16; i++) drive(1'b0, 1'b1, {N{W'(i)}}, "R6");
        for (int i = 0; i < 100; i++) drive(1'b0, 1'b1, rnd_keys(3), "R6");
        // R8: keys on both sides of the top bit
        for (int i = 0; i < 100; i++) begin
            for (int j = 0; j < N; j++)
                k[j*W +: W] = W'($urandom_range(1)) << (W - 1) | W'($urandom_range(1));
            drive(1'b0, 1'b1, k, "R8");
        end
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, '0, "R3");
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule